// File: doc/BRIEF.md
# Link Power Status Interface Monitor

This block sits between a PHY core and the parallel interface that carries control and data to a link-layer controller. It watches a link-power-status input driven by the link. That input may be held at a static level or toggled as a pulse train. From it, the block decides whether the parallel interface is active, held in reset, or disabled.

The status input is synchronized into the local clock domain. A saturating counter then measures how many consecutive cycles the synchronized level has stayed low, and any high sample clears the counter. Short low stretches, such as the low phases of a pulsed input, never reach the reset threshold, so a pulsed input counts as asserted. A low run that reaches the reset threshold puts the interface into reset. A low run that goes on to the much longer disable threshold disables the interface.

While the interface is not active, the forwarded control and data buses are forced to zero and the link request is blocked. A clock-enable request goes low while the interface is disabled. When the status input returns, the request is raised again, either at once or after a parameterized wake delay when the PHY is in low-power mode. Single-cycle pulses mark each entry into reset and each entry into the disabled state.

Top module: `lps_link_monitor`

## Requirements
- R1: The status input passes through a two-flop synchronizer. A low stretch of fewer than RESET_CYC consecutive cycles, as seen at the input, leaves the interface active with no event pulse, so a pulsed status input counts as asserted.
- R2: From the active state, the interface enters reset exactly RESET_CYC+2 clock edges after the status input goes low, and stays there while the input is held low. `rst_pulse_o` is high for that first reset cycle only.
- R3: When the low run continues, the interface moves from reset to disabled exactly DISABLE_CYC+2 edges after the input went low. `dis_pulse_o` is high for that first cycle only.
- R4: While the interface is active, `ctl_o` and `data_o` equal `ctl_i` and `data_i`. In every other state, both are all zeros.
- R5: While the interface is active, `lreq_o` follows `lreq_i`. In every other state, `lreq_o` is 0 whatever `lreq_i` does.
- R6: `clk_en_o` is 1 in the active and reset states and 0 while `st_disabled_o` is 1.
- R7: If the status input rises while the interface is in reset, the interface becomes active 3 edges after the rise, with no disable pulse in between.
- R8: If the status input rises while the interface is disabled and `low_power_i` is 0, the interface becomes active and `clk_en_o` rises 3 edges after the rise.
- R9: If the status input rises while the interface is disabled and `low_power_i` is 1, the interface becomes active WAKE_CYC+3 edges after the rise. Until then, `st_disabled_o` stays 1, `clk_en_o` stays 0 and the buses stay zero.
- R10: During and right after `rst_n` is low, the interface is disabled: `st_disabled_o` is 1, `clk_en_o` is 0, the buses and `lreq_o` are 0, and there are no pulses. With the status input high and `low_power_i` at 0, the interface becomes active 3 edges after release.
- R11: Exactly one of `st_active_o`, `st_reset_o` and `st_disabled_o` is 1 in every cycle. Each pulse lasts a single cycle and appears only on a state entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lps_i | input | 1 | Link power status from the link, asynchronous, static or pulsed |
| low_power_i | input | 1 | PHY is in low-power mode; selects the long wake delay |
| lreq_i | input | 1 | Link request from the link |
| ctl_i | input | CTL_W | Internal control bus to forward |
| data_i | input | DATA_W | Internal data bus to forward |
| lreq_o | output | 1 | Link request passed to the PHY core, blocked unless active |
| ctl_o | output | CTL_W | Gated control bus |
| data_o | output | DATA_W | Gated data bus |
| st_active_o | output | 1 | Interface is active |
| st_reset_o | output | 1 | Interface is in reset |
| st_disabled_o | output | 1 | Interface is disabled, including the wake delay |
| clk_en_o | output | 1 | Request to run the system clock |
| rst_pulse_o | output | 1 | One-cycle mark on entry into reset |
| dis_pulse_o | output | 1 | One-cycle mark on entry into disabled |

## Verification
The assertions assume that `low_power_i` is held steady from the moment the interface is disabled until it is active again. They also assume that RESET_CYC is below DISABLE_CYC, so every disable entry passes through reset. The status input itself may change at any time, because it is synchronized before use. The stimulus changes every input only at falling clock edges, changes `low_power_i` only while the interface is disabled, and changes `data_i` only when no state change is due in that cycle.

// File: rtl/lps_mon_pkg.sv
package lps_mon_pkg;

  typedef enum logic [1:0] {
    IF_ACTIVE   = 2'd0,
    IF_RESET    = 2'd1,
    IF_DISABLED = 2'd2,
    IF_WAKE     = 2'd3
  } if_state_e;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lps_low_timer.sv
module lps_low_timer #(
  parameter int RESET_CYC   = 520,
  parameter int DISABLE_CYC = 5206,
  localparam int CW         = $clog2(DISABLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic hit_rst_o,
  output logic hit_dis_o
);

  localparam logic [CW-1:0] RST_LIM = CW'(RESET_CYC);
  localparam logic [CW-1:0] DIS_LIM = CW'(DISABLE_CYC);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  // Clear on any high sample, otherwise count up and hold at the disable limit.
  always_comb begin
    run_en = 1'b1;
    if (level_i)              run_d = '0;
    else if (run_q == DIS_LIM) begin
      run_d  = run_q;
      run_en = 1'b0;
    end else                  run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= DIS_LIM;
    else if (run_en) run_q <= run_d;
  end

  assign hit_rst_o = !level_i && (run_d == RST_LIM);
  assign hit_dis_o = !level_i && (run_d == DIS_LIM);

endmodule

// File: rtl/lps_if_fsm.sv
module lps_if_fsm
  import lps_mon_pkg::*;
#(
  parameter int WAKE_CYC = 1_260_000,
  localparam int WW      = $clog2(WAKE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic low_power_i,
  input  logic hit_rst_i,
  input  logic hit_dis_i,
  output logic active_o,
  output logic in_reset_o,
  output logic disabled_o,
  output logic clk_en_o,
  output logic rst_pulse_o,
  output logic dis_pulse_o
);

  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

  if_state_e     state_q, state_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          wake_done;
  logic          rst_pulse_q, rst_pulse_d;
  logic          dis_pulse_q, dis_pulse_d;

  assign wake_done = (wake_q == WAKE_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IF_ACTIVE:   if (hit_rst_i) state_d = IF_RESET;
      IF_RESET: begin
        if (level_i)        state_d = IF_ACTIVE;
        else if (hit_dis_i) state_d = IF_DISABLED;
      end
      IF_DISABLED: if (level_i) state_d = low_power_i ? IF_WAKE : IF_ACTIVE;
      IF_WAKE: begin
        if (!level_i)       state_d = IF_DISABLED;
        else if (wake_done) state_d = IF_ACTIVE;
      end
      default:             state_d = IF_DISABLED;
    endcase
  end

  always_comb begin
    if (state_q == IF_WAKE && level_i && !wake_done) wake_d = wake_q + 1'b1;
    else                                             wake_d = '0;
  end

  always_comb begin
    rst_pulse_d = (state_d == IF_RESET) && (state_q != IF_RESET);
    dis_pulse_d = (state_d == IF_DISABLED) && (state_q == IF_RESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= IF_DISABLED;
      wake_q      <= '0;
      rst_pulse_q <= 1'b0;
      dis_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_q      <= wake_d;
      rst_pulse_q <= rst_pulse_d;
      dis_pulse_q <= dis_pulse_d;
    end
  end

  assign active_o    = (state_q == IF_ACTIVE);
  assign in_reset_o  = (state_q == IF_RESET);
  assign disabled_o  = (state_q == IF_DISABLED) || (state_q == IF_WAKE);
  assign clk_en_o    = (state_q == IF_ACTIVE) || (state_q == IF_RESET);
  assign rst_pulse_o = rst_pulse_q;
  assign dis_pulse_o = dis_pulse_q;

endmodule

// File: rtl/lps_bus_gate.sv
module lps_bus_gate #(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              pass_i,
  input  logic              lreq_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lreq_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] data_o
);

  generate
    for (genvar c = 0; c < CTL_W; c++) begin : g_ctl
      assign ctl_o[c] = ctl_i[c] & pass_i;
    end
    for (genvar b = 0; b < DATA_W; b++) begin : g_data
      assign data_o[b] = data_i[b] & pass_i;
    end
  endgenerate

  assign lreq_o = lreq_i & pass_i;

endmodule

// File: rtl/lps_link_monitor.sv
module lps_link_monitor #(
  parameter int CTL_W       = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_CYC   = 520,
  parameter int DISABLE_CYC = 5206,
  parameter int WAKE_CYC    = 1_260_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lps_i,
  input  logic              low_power_i,
  input  logic              lreq_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lreq_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              st_active_o,
  output logic              st_reset_o,
  output logic              st_disabled_o,
  output logic              clk_en_o,
  output logic              rst_pulse_o,
  output logic              dis_pulse_o
);

  logic level_s;
  logic hit_rst;
  logic hit_dis;

  lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lps_i),
    .q_o   (level_s)
  );

  lps_low_timer #(
    .RESET_CYC   (RESET_CYC),
    .DISABLE_CYC (DISABLE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (level_s),
    .hit_rst_o (hit_rst),
    .hit_dis_o (hit_dis)
  );

  lps_if_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_i     (level_s),
    .low_power_i (low_power_i),
    .hit_rst_i   (hit_rst),
    .hit_dis_i   (hit_dis),
    .active_o    (st_active_o),
    .in_reset_o  (st_reset_o),
    .disabled_o  (st_disabled_o),
    .clk_en_o    (clk_en_o),
    .rst_pulse_o (rst_pulse_o),
    .dis_pulse_o (dis_pulse_o)
  );

  lps_bus_gate #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_gate (
    .pass_i (st_active_o),
    .lreq_i (lreq_i),
    .ctl_i  (ctl_i),
    .data_i (data_i),
    .lreq_o (lreq_o),
    .ctl_o  (ctl_o),
    .data_o (data_o)
  );

endmodule

// File: rtl/lps_link_monitor_chk.sv
module lps_link_monitor_chk #(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lreq_o,
  input logic [CTL_W-1:0]  ctl_o,
  input logic [DATA_W-1:0] data_o,
  input logic              st_active_o,
  input logic              st_reset_o,
  input logic              st_disabled_o,
  input logic              clk_en_o,
  input logic              rst_pulse_o,
  input logic              dis_pulse_o
);

  AST_BUS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_active_o |-> (ctl_o == '0 && data_o == '0));                          // R4
  AST_LREQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !st_active_o |-> !lreq_o);                                               // R5
  AST_CLK_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    st_disabled_o |-> !clk_en_o);                                            // R6
  AST_CLK_ON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active_o || st_reset_o) |-> clk_en_o);                               // R6
  AST_RST_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_o |-> (st_reset_o && $past(st_active_o)));                     // R2
  AST_DIS_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pulse_o |-> (st_disabled_o && $past(st_reset_o)));                   // R3
  AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_o |=> !rst_pulse_o);                                           // R11
  AST_DIS_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pulse_o |=> !dis_pulse_o);                                           // R11
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_active_o, st_reset_o, st_disabled_o}) == 1);              // R11
  AST_RESET_ENTRY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_reset_o) |-> rst_pulse_o);                                      // R2

endmodule

bind lps_link_monitor lps_link_monitor_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lreq_o        (lreq_o),
  .ctl_o         (ctl_o),
  .data_o        (data_o),
  .st_active_o   (st_active_o),
  .st_reset_o    (st_reset_o),
  .st_disabled_o (st_disabled_o),
  .clk_en_o      (clk_en_o),
  .rst_pulse_o   (rst_pulse_o),
  .dis_pulse_o   (dis_pulse_o)
);

// File: tb/sim_lps_link_monitor.sv
`timescale 1ns/1ps
module sim_lps_link_monitor;

  localparam int R  = 40;
  localparam int D  = 400;
  localparam int WK = 100;

  typedef enum int {EV_RST = 0, EV_DIS = 1, EV_ACT = 2} ev_e;
  typedef struct {
    ev_e   kind;
    int    cyc;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lps, lp, lreq;
  logic [1:0] ctl_i;
  logic [7:0] data_i;
  logic       lreq_o;
  logic [1:0] ctl_o;
  logic [7:0] data_o;
  logic       st_act, st_rst, st_dis, clk_en, rst_pulse, dis_pulse;

  always #2.5 clk = ~clk;

  lps_link_monitor #(
    .CTL_W(2), .DATA_W(8), .SYNC_STAGES(2),
    .RESET_CYC(R), .DISABLE_CYC(D), .WAKE_CYC(WK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .lps_i(lps), .low_power_i(lp), .lreq_i(lreq),
    .ctl_i(ctl_i), .data_i(data_i), .lreq_o(lreq_o), .ctl_o(ctl_o), .data_o(data_o),
    .st_active_o(st_act), .st_reset_o(st_rst), .st_disabled_o(st_dis),
    .clk_en_o(clk_en), .rst_pulse_o(rst_pulse), .dis_pulse_o(dis_pulse)
  );

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  exp_t q[$];
  bit   prev_act = 1'b0, prev_rp = 1'b0, prev_dp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(input ev_e k, input int delay, input string req);
    exp_t e;
    e.kind = k;
    e.cyc  = cyc + delay;
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take_event(input ev_e k);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R11", "unexpected event kind", int'(k), -1);
    end else begin
      e = q.pop_front();
      check(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
      check(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
    end
  endtask

  // Monitor: pops expected events and checks outputs when they occur.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_pulse) begin
        check(!prev_rp, "R11", "reset pulse width", 2, 1);
        take_event(EV_RST);
        check(data_o == 8'h00 && ctl_o == 2'b00, "R4", "bus in reset", int'(data_o), 0);
        check(lreq_o == 1'b0, "R5", "lreq in reset", int'(lreq_o), 0);
        check(clk_en == 1'b1, "R6", "clk_en in reset", int'(clk_en), 1);
      end
      if (dis_pulse) begin
        check(!prev_dp, "R11", "disable pulse width", 2, 1);
        take_event(EV_DIS);
        check(clk_en == 1'b0, "R6", "clk_en disabled", int'(clk_en), 0);
      end
      if (st_act && !prev_act) begin
        take_event(EV_ACT);
        check(clk_en == 1'b1, "R8", "clk_en on return", int'(clk_en), 1);
        check(data_o == data_i, "R4", "bus pass on return", int'(data_o), int'(data_i));
      end
      prev_act = st_act;
      prev_rp  = rst_pulse;
      prev_dp  = dis_pulse;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    lps    = 1'b1;
    lp     = 1'b0;
    lreq   = 1'b1;
    ctl_i  = 2'b10;
    data_i = 8'h5A;
    idle(3);
    // R10: held in reset
    check(st_dis == 1'b1 && st_act == 1'b0, "R10", "disabled in reset", int'(st_dis), 1);
    check(clk_en == 1'b0, "R10", "clk_en in reset", int'(clk_en), 0);
    check(data_o == 8'h00 && lreq_o == 1'b0, "R10", "outputs in reset", int'(data_o), 0);
    check(rst_pulse == 1'b0 && dis_pulse == 1'b0, "R10", "pulses in reset", int'(rst_pulse), 0);

    rst_n = 1'b1;
    expect_ev(EV_ACT, 3, "R10");
    idle(6);
    check(data_o == 8'h5A && ctl_o == 2'b10, "R4", "bus pass active", int'(data_o), 8'h5A);
    check(lreq_o == 1'b1, "R5", "lreq pass active", int'(lreq_o), 1);
    lreq = 1'b0;
    idle(1);
    check(lreq_o == 1'b0, "R5", "lreq follows", int'(lreq_o), 0);
    lreq = 1'b1;

    // R1: pulsed input with low phases just under the threshold, then fast toggling
    for (int i = 0; i < 4; i++) begin
      lps = 1'b0; idle(R - 1); lps = 1'b1; idle(3);
    end
    for (int i = 0; i < 10; i++) begin
      lps = 1'b0; idle(1); lps = 1'b1; idle(1);
    end
    idle(5);
    check(st_act == 1'b1, "R1", "active after pulsing", int'(st_act), 1);
    check(q.size() == 0, "R1", "pending events", q.size(), 0);
    data_i = 8'hC3;
    idle(1);
    check(data_o == 8'hC3, "R4", "bus pass new data", int'(data_o), 8'hC3);

    // R2, R7: reset then return before the disable threshold
    expect_ev(EV_RST, R + 2, "R2");
    lps = 1'b0;
    idle(R + 5);
    lreq = 1'b0; idle(1); lreq = 1'b1; idle(1);
    check(st_rst == 1'b1, "R2", "held in reset", int'(st_rst), 1);
    check(lreq_o == 1'b0 && data_o == 8'h00 && ctl_o == 2'b00, "R5", "request ignored", int'(lreq_o), 0);
    idle(10);
    expect_ev(EV_ACT, 3, "R7");
    lps = 1'b1;
    idle(10);

    // R3, R8: disable, then return with no low-power delay
    expect_ev(EV_RST, R + 2, "R2");
    expect_ev(EV_DIS, D + 2, "R3");
    lps = 1'b0;
    idle(D + 20);
    check(st_dis == 1'b1 && clk_en == 1'b0, "R6", "disabled clock off", int'(clk_en), 0);
    expect_ev(EV_ACT, 3, "R8");
    lps = 1'b1;
    idle(10);

    // R9: disable, then return in low-power mode
    expect_ev(EV_RST, R + 2, "R2");
    expect_ev(EV_DIS, D + 2, "R3");
    lps = 1'b0;
    idle(D + 10);
    lp = 1'b1;
    expect_ev(EV_ACT, WK + 3, "R9");
    lps = 1'b1;
    idle(WK / 2);
    check(st_dis == 1'b1 && clk_en == 1'b0, "R9", "still waking", int'(clk_en), 0);
    check(data_o == 8'h00 && lreq_o == 1'b0, "R9", "bus held while waking", int'(data_o), 0);
    idle(WK);
    lp = 1'b0;
    idle(10);
    check(st_act == 1'b1, "R9", "active after wake", int'(st_act), 1);
    check(q.size() == 0, "R11", "pending events at end", q.size(), 0);
    finish_run();
  end

endmodule